// File: doc/BRIEF.md
# Supply Brownout and Battery Flag Logic

This block sits between a set of analog comparators and the status register of a supply monitor. It turns the comparator results into sticky status bits and drives an active-low reset pin. The main supply has two comparator inputs. One says the supply has fallen below the selected trip level. The other says the supply has climbed back above that level plus a hysteresis margin. A 3-bit threshold selection is passed on to the analog side as a code from 0 to 5, so six trip levels can be chosen.

The brownout flag and the reset pin are deliberately kept apart. The pin goes low as soon as a brownout is seen, and it rises again only when the recovery comparator reports a good supply. The flag stays set until software reads the status.

The two battery flags change only when software asks for a measurement. A request raised while the chip runs from the battery waits until main power is back. When the request is served, the flags take the comparator results and the request clears itself.

Top module: `pwr_status_flags`

## Requirements
- R1: `trip_code_o` equals `trip_sel_i` for selections 0 to 5, and equals 5 for selections 6 and 7. It follows the input with no clock delay.
- R2: On a clock edge where `sup_low_i` is 1, `brown_flag_o` becomes 1 and `rst_pin_n_o` becomes 0 after that edge.
- R3: Once low, `rst_pin_n_o` stays low until an edge where `sup_ok_i` is 1 and `sup_low_i` is 0. After that edge the pin is 1. A supply that merely stops being low does not release the pin.
- R4: `brown_flag_o` clears after an edge where `stat_rd_i` is 1 and `sup_low_i` is 0. It is not cleared when the supply recovers.
- R5: When `stat_rd_i` and `sup_low_i` are both 1 on the same edge, `brown_flag_o` is 1 after that edge.
- R6: `meas_req_o` becomes 1 after an edge where `meas_set_i` is 1. On the next edge where `meas_req_o` is 1 and `on_batt_i` is 0, the battery flags are loaded from the comparators. After that same edge `meas_req_o` is 0, unless `meas_set_i` was also 1 on that edge.
- R7: A measurement encodes the battery level as follows. With `bat_lt75_i` at 1, both `bat85_flag_o` and `bat75_flag_o` become 1. With only `bat_lt85_i` at 1, only `bat85_flag_o` becomes 1. With neither input at 1, both flags become 0.
- R8: While `on_batt_i` is 1, the battery flags keep their values and a pending `meas_req_o` stays 1.
- R9: While `rst_n` is low, the outputs are held at `brown_flag_o`=0, `rst_pin_n_o`=1, both battery flags 0 and `meas_req_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trip_sel_i | input | 3 | Requested supply trip level |
| trip_code_o | output | 3 | Trip level passed to the analog side, saturated at 5 |
| sup_low_i | input | 1 | Supply below the trip level |
| sup_ok_i | input | 1 | Supply above the trip level plus hysteresis |
| stat_rd_i | input | 1 | Status read strobe |
| brown_flag_o | output | 1 | Sticky brownout flag |
| rst_pin_n_o | output | 1 | Reset output, active low |
| on_batt_i | input | 1 | Chip is running from the backup battery |
| meas_set_i | input | 1 | Software sets the measurement request |
| bat_lt85_i | input | 1 | Battery below 85% of nominal |
| bat_lt75_i | input | 1 | Battery below 75% of nominal |
| meas_req_o | output | 1 | Pending measurement request |
| bat85_flag_o | output | 1 | Battery-low flag for the 85% level |
| bat75_flag_o | output | 1 | Battery-low flag for the 75% level |

## Verification
The trip code is combinational, so it is checked in the same cycle its selection is applied. The brownout flag, the reset pin and the request bit each settle one edge after the input that moves them. The battery flags change one edge after the request is seen, which is two edges after the request is set when the chip is not on the battery. The bench applies inputs after the falling edge. It steps a behavioural model once for each rising edge and compares all outputs shortly after that edge, so every result is checked in the cycle it is due.

// File: rtl/pwr_status_flags.sv
module pwr_status_flags #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] trip_sel_i,
  output logic [SEL_W-1:0] trip_code_o,
  input  logic             sup_low_i,
  input  logic             sup_ok_i,
  input  logic             stat_rd_i,
  output logic             brown_flag_o,
  output logic             rst_pin_n_o,
  input  logic             on_batt_i,
  input  logic             meas_set_i,
  input  logic             bat_lt85_i,
  input  logic             bat_lt75_i,
  output logic             meas_req_o,
  output logic             bat85_flag_o,
  output logic             bat75_flag_o
);
  localparam logic [SEL_W-1:0] SEL_CAP = SEL_W'(MAX_SEL);

  logic sample;

  assign trip_code_o = (trip_sel_i > SEL_CAP) ? SEL_CAP : trip_sel_i;
  assign sample      = meas_req_o & ~on_batt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brown_flag_o <= 1'b0;
      rst_pin_n_o  <= 1'b1;
    end else begin
      if (sup_low_i)      brown_flag_o <= 1'b1;
      else if (stat_rd_i) brown_flag_o <= 1'b0;
      if (sup_low_i)      rst_pin_n_o  <= 1'b0;
      else if (sup_ok_i)  rst_pin_n_o  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_req_o   <= 1'b0;
      bat85_flag_o <= 1'b0;
      bat75_flag_o <= 1'b0;
    end else begin
      meas_req_o <= meas_set_i | (meas_req_o & on_batt_i);
      if (sample) begin
        bat85_flag_o <= bat_lt85_i | bat_lt75_i;
        bat75_flag_o <= bat_lt75_i;
      end
    end
  end
endmodule

module pwr_status_flags_chk #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] trip_code_o,
  input logic             sup_low_i,
  input logic             sup_ok_i,
  input logic             stat_rd_i,
  input logic             brown_flag_o,
  input logic             rst_pin_n_o,
  input logic             on_batt_i,
  input logic             meas_set_i,
  input logic             meas_req_o,
  input logic             bat85_flag_o,
  input logic             bat75_flag_o
);
  AST_TRIP_CAP: assert property (@(posedge clk) disable iff (!rst_n) trip_code_o <= SEL_W'(MAX_SEL)); // R1
  AST_LOW_TRIPS: assert property (@(posedge clk) disable iff (!rst_n) sup_low_i |=> (brown_flag_o && !rst_pin_n_o)); // R2
  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!rst_pin_n_o && !sup_ok_i) |=> !rst_pin_n_o); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd_i && !sup_low_i) |=> !brown_flag_o); // R4
  AST_REQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n) (meas_req_o && !on_batt_i && !meas_set_i) |=> !meas_req_o); // R6
  AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n) bat75_flag_o |-> bat85_flag_o); // R7
  AST_BATT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) on_batt_i |=> ($stable(bat85_flag_o) && $stable(bat75_flag_o))); // R8
  AST_REQ_PENDS: assert property (@(posedge clk) disable iff (!rst_n) (meas_req_o && on_batt_i) |=> meas_req_o); // R8
endmodule

bind pwr_status_flags pwr_status_flags_chk #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) i_chk (.*);

// File: tb/test_pwr_status_flags.sv
module test_pwr_status_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] trip_sel_i = '0;
  logic [2:0] trip_code_o;
  logic sup_low_i = 0, sup_ok_i = 0, stat_rd_i = 0, on_batt_i = 0, meas_set_i = 0;
  logic bat_lt85_i = 0, bat_lt75_i = 0;
  logic brown_flag_o, rst_pin_n_o, meas_req_o, bat85_flag_o, bat75_flag_o;

  int n_chk = 0, n_fail = 0;
  int m_brown = 0, m_pin = 1, m_req = 0, m85 = 0, m75 = 0;

  always #4 clk = ~clk;

  pwr_status_flags i_pwr_status_flags (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 trip_code", trip_code_o, (trip_sel_i > 5) ? 5 : trip_sel_i);
    chk("R2/R4/R5 brown_flag", brown_flag_o, m_brown);
    chk("R2/R3 rst_pin", rst_pin_n_o, m_pin);
    chk("R6/R8 meas_req", meas_req_o, m_req);
    chk("R6/R7/R8 bat85", bat85_flag_o, m85);
    chk("R6/R7/R8 bat75", bat75_flag_o, m75);
  endtask

  task automatic cyc(input int sl, input int so, input int rd, input int ob,
                     input int ms, input int l85, input int l75, input int sel);
    int nb, np, nr;
    @(negedge clk);
    sup_low_i = sl[0]; sup_ok_i = so[0]; stat_rd_i = rd[0]; on_batt_i = ob[0];
    meas_set_i = ms[0]; bat_lt85_i = l85[0]; bat_lt75_i = l75[0]; trip_sel_i = sel[2:0];
    #1 chk("R1 trip_code comb", trip_code_o, (sel > 5) ? 5 : sel);
    @(posedge clk);
    nb = sl ? 1 : (rd ? 0 : m_brown);
    np = sl ? 0 : (so ? 1 : m_pin);
    if (m_req && !ob) begin m85 = (l85 || l75) ? 1 : 0; m75 = l75; end
    nr = (ms || (m_req && ob)) ? 1 : 0;
    m_brown = nb; m_pin = np; m_req = nr;
    #1 check_all();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    sup_low_i = 1; bat_lt75_i = 1; meas_set_i = 1;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state with active inputs
    chk("R9 brown", brown_flag_o, 0);
    chk("R9 pin", rst_pin_n_o, 1);
    chk("R9 req", meas_req_o, 0);
    chk("R9 b85", bat85_flag_o, 0);
    chk("R9 b75", bat75_flag_o, 0);
    @(negedge clk);
    sup_low_i = 0; bat_lt75_i = 0; meas_set_i = 0;
    rst_n = 1;
    // R1 sweep of selections
    for (int s = 0; s < 8; s++) cyc(0, 0, 0, 0, 0, 0, 0, s);
    // R2 brownout, R3 pin held after low goes away
    cyc(1, 0, 0, 0, 0, 0, 0, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, 2);
    // R5 read during brownout keeps flag
    cyc(1, 0, 1, 0, 0, 0, 0, 7);
    // R4 read clears flag, pin still low
    cyc(0, 0, 1, 0, 0, 0, 0, 7);
    // R3 low and ok together: low wins
    cyc(1, 1, 0, 0, 0, 0, 0, 3);
    // R3 release; R4 flag not cleared by recovery
    cyc(0, 1, 0, 0, 0, 0, 0, 3);
    cyc(0, 0, 0, 0, 0, 0, 0, 3);
    cyc(0, 0, 1, 0, 0, 0, 0, 3);
    // R7 level 85 only
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    // R7 below 75
    cyc(0, 0, 0, 0, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    // R8 request while on battery pends, flags held
    cyc(0, 0, 0, 1, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    // R6 served once power returns
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      automatic int r = $urandom;
      cyc((r % 5) == 0, r[3], r[4], r[5] & r[6], r[7] & r[8], r[9], r[10] & r[11], r[14:12]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule